// File: doc/BRIEF.md
# Smart-Card Serial Receiver with Parity Error Signalling

This block receives asynchronous character frames from a smart card over a single half-duplex data wire. The local transmit and receive pins share that wire as a wired-OR: the card drives it, and the receiver can pull it low. A frame holds one start bit, eight data bits sent least significant bit first, one even-parity bit and one stop bit. Bit timing comes from a prescaler and an 8-bit divider. Each bit lasts sixteen divider ticks and is sampled at its middle tick.

When the received parity is wrong, the receiver does more than record it. It pulls the shared wire low for the whole stop-bit slot, and the card reads this as a request to send the character again. At the end of every frame the receiver loads a receive buffer and raises a receive-complete flag and an interrupt request. Reading the buffer clears the flag and the parity-error bit. The interrupt request is cleared by an acknowledge or by a software clear.

Top module: `scard_rx`

## Requirements
- R1: The eight data bits after the start bit are assembled least significant bit first and appear on `buf_data_o` when the frame completes. The buffer holds its value until the next frame completes.
- R2: One bit lasts 16·(n+1)·p clock cycles, where n is `div_val_i`. `src_sel_i` chooses p: 2'b00 gives p=1, 2'b01 gives p=8, and 2'b10 or 2'b11 gives p=32.
- R3: `rx_done_o` sets when a frame completes. It clears in the cycle after a `buf_rd_i` pulse, unless a new frame completes in that same cycle.
- R4: `irq_o` sets when a frame completes and is not cleared by a buffer read. It clears after a pulse on `irq_ack_i` or on `irq_clr_i`.
- R5: Parity is even. An error exists when the XOR of the eight data bits and the parity bit is 1. `par_err_o` latches this result with the frame and clears together with `rx_done_o` on a buffer read.
- R6: On a parity error, `pull_low_o` is 1 (pulling the line low) from the start of the stop-bit slot to its end, and is released after that slot. Without a parity error, `pull_low_o` stays 0 for the whole frame.
- R7: A start bit is accepted only on a high-to-low transition of the line while `rx_en_i` is 1. Clearing `rx_en_i` aborts a frame in progress, releases `pull_low_o` on the next cycle, and no completion is reported for that frame.
- R8: If the line is high again at the middle of the start bit, the low pulse is treated as a glitch. No frame is received, and the receiver returns to waiting for a start bit.
- R9: After a frame ends, no new start bit is accepted until the line has first been seen high. A line that stays low after the stop slot produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Observed level of the shared data wire |
| pull_low_o | output | 1 | 1 = pull the shared wire low (error signal) |
| div_val_i | input | 8 | Bit-rate divider value n |
| src_sel_i | input | 2 | Prescaler select: 00 /1, 01 /8, 1x /32 |
| rx_en_i | input | 1 | Receive enable |
| buf_rd_i | input | 1 | Receive buffer read strobe |
| buf_data_o | output | 8 | Receive buffer |
| rx_done_o | output | 1 | Receive-complete flag |
| par_err_o | output | 1 | Parity error of the buffered frame |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_clr_i | input | 1 | Software clear of the interrupt request |

## Verification
A slip in the sub-bit counter or in the bit index shows up at the ports within one frame. The data reaches the buffer shifted or mirrored, and the parity verdict flips, one frame time after the start edge. A receiver that falls out of step with the stop slot is seen directly on `pull_low_o`. The pull-down then appears in the wrong half of the stop bit, or stays on past it, and the wired line holds low so the next character fails. A control path that returns to idle too early, for example after a glitch or with the line still low, reports a phantom frame of zeros or ones on `rx_done_o` about ten bit times later.

// File: rtl/scard_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the smart-card receiver.
package scard_rx_pkg;
    // Receiver control states, in the order a frame passes through them.
    typedef enum logic [2:0] {
        ST_WAIT_HIGH,   // line must read high before a start is accepted
        ST_IDLE,        // armed, waiting for the line to drop
        ST_START,       // counting to the middle of the start bit
        ST_DATA,        // sampling the data bits
        ST_PARITY,      // sampling the parity bit
        ST_GUARD,       // half bit from parity middle to stop-slot start
        ST_STOP         // stop slot; pull-down active on parity error
    } rx_state_t;
endpackage

// File: rtl/scard_rx_sync.sv
`timescale 1ns/1ps
// Module: scard_rx_sync
// Brings the asynchronous line level into the clock domain.
// Assumes STAGES >= 2. Resets to the idle (high) level.
module scard_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scard_rx_tick.sv
`timescale 1ns/1ps
// Module: scard_rx_tick
// Makes the sub-bit tick. A prescaler divides the clock by 1, PRE_B or PRE_C.
// A divider then emits one tick every (div_val+1) prescaler pulses.
// Assumes that restart realigns both counters on a start edge.
module scard_rx_tick #(
    parameter int DIV_W = 8,
    parameter int PRE_B = 8,
    parameter int PRE_C = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [1:0]       sel,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    localparam int PW = (PRE_C > 1) ? $clog2(PRE_C) : 1;

    logic [PW-1:0]    pre_cnt;
    logic [PW-1:0]    pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_pulse;

    // Purpose: pick the prescaler terminal count from the select code.
    always_comb begin
        case (sel)
            2'b00:   pre_lim = '0;
            2'b01:   pre_lim = PW'(PRE_B - 1);
            default: pre_lim = PW'(PRE_C - 1);
        endcase
    end

    assign pre_pulse = (pre_cnt == pre_lim) && !restart;
    assign tick      = pre_pulse && (div_cnt == div_val);

    // Purpose: run the prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)      pre_cnt <= '0;
        else if (pre_cnt == pre_lim) pre_cnt <= '0;
        else                         pre_cnt <= pre_cnt + 1'b1;
    end

    // Purpose: count prescaler pulses up to the divider value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_cnt <= '0;
        else if (pre_pulse)    div_cnt <= (div_cnt == div_val) ? '0 : div_cnt + 1'b1;
    end
endmodule

// File: rtl/scard_rx_frame.sv
`timescale 1ns/1ps
// Module: scard_rx_frame
// Frame sequencer. It detects the start, samples each bit at its middle tick,
// checks even parity and drives the pull-down through the stop slot on error.
// Assumes a synchronized line and OVERSAMPLE ticks per bit.
module scard_rx_frame
    import scard_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 line,
    input  logic                 tick,
    output logic                 restart,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr,
    output logic                 pull_low
);
    localparam int SW   = $clog2(OVERSAMPLE);
    localparam int BW   = $clog2(DATA_BITS + 1);
    localparam int HALF = OVERSAMPLE / 2;

    rx_state_t            state;
    logic [SW-1:0]        sub;
    logic [SW-1:0]        wrap_pt;
    logic [BW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 perr_q;
    logic                 at_pt;

    // Purpose: choose a half-bit or full-bit sampling distance per state.
    always_comb begin
        if (state == ST_START || state == ST_GUARD) wrap_pt = SW'(HALF - 1);
        else                                        wrap_pt = SW'(OVERSAMPLE - 1);
    end

    assign at_pt    = tick && (sub == wrap_pt);
    assign restart  = en && (state == ST_IDLE) && !line;
    assign done     = (state == ST_STOP) && at_pt;
    assign pull_low = (state == ST_STOP) && perr_q;
    assign data     = shreg;
    assign perr     = perr_q;

    // Purpose: sub-bit tick counter, held at zero while not framing.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || state == ST_IDLE || state == ST_WAIT_HIGH) sub <= '0;
        else if (tick) sub <= (sub == wrap_pt) ? '0 : sub + 1'b1;
    end

    // Purpose: step the frame state machine and capture bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT_HIGH;
            bit_idx <= '0;
            shreg   <= '0;
            perr_q  <= 1'b0;
        end else if (!en) begin
            state <= ST_WAIT_HIGH;
        end else begin
            case (state)
                ST_WAIT_HIGH: if (line) state <= ST_IDLE;
                ST_IDLE:      if (!line) state <= ST_START;
                ST_START: if (at_pt) begin
                    bit_idx <= '0;
                    state   <= line ? ST_WAIT_HIGH : ST_DATA;
                end
                ST_DATA: if (at_pt) begin
                    shreg <= {line, shreg[DATA_BITS-1:1]};
                    if (bit_idx == BW'(DATA_BITS - 1)) state <= ST_PARITY;
                    else bit_idx <= bit_idx + 1'b1;
                end
                ST_PARITY: if (at_pt) begin
                    perr_q <= ^{shreg, line};
                    state  <= ST_GUARD;
                end
                ST_GUARD: if (at_pt) state <= ST_STOP;
                ST_STOP:  if (at_pt) state <= ST_WAIT_HIGH;
                default:  state <= ST_WAIT_HIGH;
            endcase
        end
    end
endmodule

// File: rtl/scard_rx_status.sv
`timescale 1ns/1ps
// Module: scard_rx_status
// Receive buffer, completion flag, parity-error bit and interrupt request.
// Assumes that a completion in the same cycle wins over a clear.
module scard_rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 perr,
    input  logic                 rd,
    input  logic                 ack,
    input  logic                 clr,
    output logic [DATA_BITS-1:0] buf_q,
    output logic                 rx_done,
    output logic                 par_err,
    output logic                 irq
);
    // Purpose: load the buffer on completion and clear the flags on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            rx_done <= 1'b0;
            par_err <= 1'b0;
        end else if (done) begin
            buf_q   <= data;
            rx_done <= 1'b1;
            par_err <= perr;
        end else if (rd) begin
            rx_done <= 1'b0;
            par_err <= 1'b0;
        end
    end

    // Purpose: set the interrupt request on completion, clear on ack or write.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (done)       irq <= 1'b1;
        else if (ack || clr) irq <= 1'b0;
    end
endmodule

// File: rtl/scard_rx.sv
`timescale 1ns/1ps
// Module: scard_rx
// Smart-card character receiver on a wired-OR half-duplex line. It pulls
// the line low through the stop slot when the parity is wrong.
// Assumes that line_i is the combined wire level, including the own pull-down.
module scard_rx #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int DIV_W       = 8,
    parameter int PRE_B       = 8,
    parameter int PRE_C       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 line_i,
    output logic                 pull_low_o,
    input  logic [DIV_W-1:0]     div_val_i,
    input  logic [1:0]           src_sel_i,
    input  logic                 rx_en_i,
    input  logic                 buf_rd_i,
    output logic [DATA_BITS-1:0] buf_data_o,
    output logic                 rx_done_o,
    output logic                 par_err_o,
    output logic                 irq_o,
    input  logic                 irq_ack_i,
    input  logic                 irq_clr_i
);
    logic                 line_s;
    logic                 restart;
    logic                 tick;
    logic                 frame_done;
    logic [DATA_BITS-1:0] frame_data;
    logic                 frame_perr;

    scard_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_i), .rst_n(rst_ni), .d(line_i), .q(line_s)
    );

    scard_rx_tick #(.DIV_W(DIV_W), .PRE_B(PRE_B), .PRE_C(PRE_C)) u_tick (
        .clk(clk_i), .rst_n(rst_ni), .restart(restart),
        .sel(src_sel_i), .div_val(div_val_i), .tick(tick)
    );

    scard_rx_frame #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_frame (
        .clk(clk_i), .rst_n(rst_ni), .en(rx_en_i), .line(line_s), .tick(tick),
        .restart(restart), .done(frame_done), .data(frame_data),
        .perr(frame_perr), .pull_low(pull_low_o)
    );

    scard_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk(clk_i), .rst_n(rst_ni), .done(frame_done), .data(frame_data),
        .perr(frame_perr), .rd(buf_rd_i), .ack(irq_ack_i), .clr(irq_clr_i),
        .buf_q(buf_data_o), .rx_done(rx_done_o), .par_err(par_err_o), .irq(irq_o)
    );
endmodule

// File: rtl/scard_rx_chk.sv
`timescale 1ns/1ps
// Module: scard_rx_chk
// Property checker for scard_rx. It is bound to the top and sees the ports
// and the internal completion strobe.
module scard_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_done,
    input logic                 buf_rd,
    input logic                 irq_ack,
    input logic                 irq_clr,
    input logic                 rx_en,
    input logic                 rx_done,
    input logic                 par_err,
    input logic                 irq,
    input logic                 pull_low,
    input logic [DATA_BITS-1:0] buf_data
);
    assert_buf_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(buf_data));

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (rx_done && irq));

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !frame_done) |=> (!rx_done && !par_err));

    assert_irq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || irq_clr) && !frame_done) |=> !irq);

    assert_perr_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rx_done);

    assert_pull_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> ($past(frame_done) || !$past(rx_en)));

    assert_pull_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !pull_low);
endmodule

bind scard_rx scard_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk_i), .rst_n(rst_ni), .frame_done(frame_done), .buf_rd(buf_rd_i),
    .irq_ack(irq_ack_i), .irq_clr(irq_clr_i), .rx_en(rx_en_i),
    .rx_done(rx_done_o), .par_err(par_err_o), .irq(irq_o),
    .pull_low(pull_low_o), .buf_data(buf_data_o)
);

// File: tb/scard_rx_bench.sv
`timescale 1ns/1ps
// Bench for scard_rx: a vector table walked by one loop, then directed cases.
module scard_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_drv = 1'b1;
    logic       line;
    logic       pull_low;
    logic [7:0] div_val = 8'd1;
    logic [1:0] src_sel = 2'b00;
    logic       rx_en = 1'b0;
    logic       buf_rd = 1'b0;
    logic [7:0] buf_data;
    logic       rx_done, par_err, irq;
    logic       irq_ack = 1'b0, irq_clr = 1'b0;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Wired-OR line: the card drives it, and the local pull-down forces it low.
    assign line = card_drv & ~pull_low;

    scard_rx u_scard_rx (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .pull_low_o(pull_low),
        .div_val_i(div_val), .src_sel_i(src_sel), .rx_en_i(rx_en),
        .buf_rd_i(buf_rd), .buf_data_o(buf_data), .rx_done_o(rx_done),
        .par_err_o(par_err), .irq_o(irq), .irq_ack_i(irq_ack), .irq_clr_i(irq_clr)
    );

    // Vector: {src_sel[1:0], n[7:0], data[7:0], parity_flip}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {2'b00, 8'd1, 8'hA5, 1'b0},
        {2'b00, 8'd1, 8'h3C, 1'b1},
        {2'b01, 8'd0, 8'h01, 1'b0},
        {2'b01, 8'd0, 8'hFE, 1'b1},
        {2'b10, 8'd0, 8'h80, 1'b0},
        {2'b00, 8'd3, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    function automatic int bit_clks(input logic [1:0] sel, input logic [7:0] n);
        int p;
        p = (sel == 2'b00) ? 1 : (sel == 2'b01) ? 8 : 32;
        return 16 * (int'(n) + 1) * p;
    endfunction

    // Drive the start bit, the data bits (LSB first) and the parity bit, then release to high.
    task automatic drive_bits(input logic [7:0] d, input logic flip, input int t);
        card_drv = 1'b0; wait_clks(t);
        for (int i = 0; i < 8; i++) begin card_drv = d[i]; wait_clks(t); end
        card_drv = ^d ^ flip; wait_clks(t);
        card_drv = 1'b1;
    endtask

    task automatic read_buf;
        buf_rd = 1'b1; wait_clks(1); buf_rd = 1'b0; wait_clks(1);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        check("R3 reset rx_done", rx_done, 0);
        check("R4 reset irq", irq, 0);
        check("R5 reset par_err", par_err, 0);
        check("R6 reset pull_low", pull_low, 0);
        rx_en = 1'b1;
        wait_clks(4);

        // Table walk: R1 data order, R2 bit timing per select, R3..R6 flags and error signal.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] s; logic [7:0] n; logic [7:0] d; logic f;
            {s, n, d, f} = VEC[i];
            src_sel = s; div_val = n;
            t = bit_clks(s, n);
            wait_clks(4);
            drive_bits(d, f, t);
            wait_clks(t / 2);
            check("R6 pull_low mid stop", pull_low, f);
            wait_clks(t / 2 + t / 4);
            check("R6 pull released", pull_low, 0);
            check("R3 rx_done set", rx_done, 1);
            check("R4 irq set", irq, 1);
            check("R1 R2 buffer data", buf_data, d);
            check("R5 parity error", par_err, f);
            read_buf();
            check("R3 read clears rx_done", rx_done, 0);
            check("R5 read clears par_err", par_err, 0);
            check("R4 read keeps irq", irq, 1);
            if (i % 2 == 1) begin irq_ack = 1'b1; wait_clks(1); irq_ack = 1'b0; end
            else            begin irq_clr = 1'b1; wait_clks(1); irq_clr = 1'b0; end
            wait_clks(1);
            check("R4 irq cleared", irq, 0);
        end

        src_sel = 2'b00; div_val = 8'd1;
        t = bit_clks(2'b00, 8'd1);
        wait_clks(8);

        // R7: frame ignored while disabled.
        rx_en = 1'b0;
        drive_bits(8'h77, 1'b0, t);
        wait_clks(2 * t);
        check("R7 disabled no frame", rx_done, 0);
        check("R7 disabled no irq", irq, 0);
        rx_en = 1'b1;
        wait_clks(8);

        // R7: abort during the error stop slot releases the pull-down.
        drive_bits(8'h12, 1'b1, t);
        wait_clks(t / 2);
        check("R6 pull active before abort", pull_low, 1);
        rx_en = 1'b0;
        wait_clks(2);
        check("R7 abort releases pull", pull_low, 0);
        wait_clks(t);
        check("R7 abort no completion", rx_done, 0);
        rx_en = 1'b1;
        wait_clks(8);

        // R8: short low pulse is a glitch, and the receiver re-arms afterwards.
        card_drv = 1'b0; wait_clks(t / 4); card_drv = 1'b1;
        wait_clks(2 * t);
        check("R8 glitch no frame", rx_done, 0);
        drive_bits(8'h5A, 1'b0, t);
        wait_clks(t + t / 4);
        check("R8 frame after glitch", buf_data, 8'h5A);
        read_buf();
        irq_clr = 1'b1; wait_clks(1); irq_clr = 1'b0;
        wait_clks(4);

        // R9: the line stays low past the stop slot, so no new start is accepted.
        drive_bits(8'h0F, 1'b1, t);
        wait_clks(t / 2);
        card_drv = 1'b0;
        wait_clks(t / 2 + t / 4);
        check("R9 first frame done", rx_done, 1);
        read_buf();
        wait_clks(11 * t);
        check("R9 no frame while low", rx_done, 0);
        card_drv = 1'b1;
        wait_clks(2 * t);
        drive_bits(8'hC3, 1'b0, t);
        wait_clks(t + t / 4);
        check("R9 frame after high", buf_data, 8'hC3);
        check("R9 done after high", rx_done, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule